// File: doc/BRIEF.md
# Sigma-Delta Conversion Counter

This block is the digital back end of a first-order sigma-delta converter. A small divider produces an oversampling tick from the input clock at a rate of one, one half or one quarter of that clock. The tick is exported so that the modulator can step in time with the counter. A start request latches the divide and length settings and clears an up/down counter. While the conversion runs, every oversampling tick adds one for a high modulator bit or subtracts one for a low bit, for a preset number of input clock cycles.

When the length has elapsed, the net count is normalised to the number of ticks that were taken. It is then scaled so that a bitstream with seven high bits in every ten reads as half the reference, and a 16-bit word is packed from it. The word holds a sign bit, an overrange bit and fourteen data bits. It goes into a holding register that keeps its value between conversions. A ready output is low while a conversion is in flight. An abort input ends a conversion at once and leaves the held word as it was.

The scaled value is clamped to the range from minus twice full scale to just under twice full scale before it is packed. A purely two-valued bitstream can reach at most 1.25 times the reference, so the clamp is never reached in normal use.

Top module: `sd_decim_counter`

## Requirements
- R1: After reset, `ready` is 1 and `result` is 16'h0000.
- R2: A start (`start`=1 while `ready`=1 and `abort`=0) drives `ready` to 0 from the next cycle. `ready` then stays 0 for exactly L+1 clock cycles. `len_sel` picks L: 0→LEN0, 1→LEN1, 2→LEN2, 3→LEN3, with defaults of 10240, 20480, 81920 and 102400 input clock cycles.
- R3: `osc_tick` pulses once every D clock cycles. `div_sel` picks D: 0→1, 1→2, 2 or 3→4. An accepted start restarts the divider phase, so a conversion takes exactly L/D ticks.
- R4: On each tick during a conversion, the counter adds 1 when `mod_bit` is 1 and subtracts 1 when `mod_bit` is 0. It is cleared at the accepted start.
- R5: The value v is the net count C scaled as v = round(C·D·20480/L). A stream that is high 7 of every 10 ticks gives v = +8192 (half of the reference), 5 of 10 gives 0, and 3 of 10 gives −8192.
- R6: `result[15]` is the sign (v<0). `result[14]` is overrange, set when v>16383 or v<−16384. `result[13:0]` holds the low 14 bits of v in two's complement. A stream of all ones gives 16'h5000 and a stream of all zeros gives 16'hF000. `result` changes only on the cycle in which `ready` returns to 1.
- R7: A start while `ready`=0 is ignored: the length of the conversion and its result are unchanged.
- R8: `div_sel` and `len_sel` are sampled only at the accepted start. Changing them during a conversion has no effect on its length or its result.
- R9: `abort`=1 makes `ready` 1 on the next cycle and clears the counter. `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request |
| abort | input | 1 | End the running conversion without storing a result |
| div_sel | input | 2 | Oversampling divide setting |
| len_sel | input | 2 | Conversion length setting |
| mod_bit | input | 1 | Modulator output bit |
| osc_tick | output | 1 | Oversampling clock enable |
| ready | output | 1 | High when idle, low during a conversion |
| result | output | 16 | Held result {sign, overrange, data[13:0]} |

## Verification
A behavioural source drives periodic bitstreams in step with `osc_tick`. Duty cycles of 7/10, 5/10 and 3/10 separate a correct scale and sign from an offset or a mirrored count. The 1/10 and 9/10 patterns land exactly on the in-range limit and on the overrange limit, which exposes off-by-one errors in the overrange compare. Full-high and full-low streams show the largest codes. Patterns of 17/32, 15/32 and 19/20 give small and odd values that bring out errors in the low data bits. Each pattern runs under a different pairing of divider and length, so a wrong normalisation for either setting changes the word.

// File: rtl/sd_decim_pkg.sv
package sd_decim_pkg;

    localparam int DATA_W   = 14;
    localparam int RES_W    = DATA_W + 2;
    localparam int FS       = 1 << DATA_W;
    // reference sits at 80% of the full count swing
    localparam int REF_SPAN = FS + FS / 4;
    localparam int SCALE_SH = 18;
    localparam int VAL_W    = 48;

    localparam logic signed [VAL_W-1:0] V_FS  = VAL_W'(FS);
    localparam logic signed [VAL_W-1:0] V_NFS = -V_FS;
    localparam logic signed [VAL_W-1:0] V_HI  = VAL_W'(2 * FS - 1);
    localparam logic signed [VAL_W-1:0] V_LO  = -VAL_W'(2 * FS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOAD = 2'd2
    } conv_state_e;

    typedef struct packed {
        logic              sign;
        logic              ovr;
        logic [DATA_W-1:0] mag;
    } result_t;

    function automatic logic [VAL_W-1:0] scale_k(input int unsigned len);
        return (VAL_W'(REF_SPAN) << SCALE_SH) / VAL_W'(len);
    endfunction

    function automatic logic [1:0] div_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic result_t pack_code(input logic signed [VAL_W-1:0] v);
        logic signed [VAL_W-1:0] c;
        result_t r;
        c = v;
        if (v > V_HI)      c = V_HI;
        else if (v < V_LO) c = V_LO;
        r.sign = c[VAL_W-1];
        r.ovr  = (c >= V_FS) || (c < V_NFS);
        r.mag  = c[DATA_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/sd_osc_div.sv
module sd_osc_div (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync,
    input  logic [1:0] div_sel,
    output logic       tick
);
    logic [1:0] phase_q;
    logic [1:0] lim;

    always_comb begin
        case (div_sel)
            2'd0:    lim = 2'd0;
            2'd1:    lim = 2'd1;
            default: lim = 2'd3;
        endcase
    end

    assign tick = (phase_q == lim);

    always_ff @(posedge clk) begin
        if (rst || sync)  phase_q <= 2'd0;
        else if (tick)    phase_q <= 2'd0;
        else              phase_q <= phase_q + 2'd1;
    end
endmodule

// File: rtl/sd_updown.sv
module sd_updown #(
    parameter int W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                en,
    input  logic                up,
    output logic signed [W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst || clr)  acc <= '0;
        else if (en)     acc <= up ? acc + W'(1) : acc - W'(1);
    end
endmodule

// File: rtl/sd_result_fmt.sv
module sd_result_fmt
    import sd_decim_pkg::*;
#(
    parameter int ACC_W = 18
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic [1:0]              div_log,
    input  logic [VAL_W-1:0]        k,
    output result_t                 res
);
    logic signed [VAL_W-1:0] norm;
    logic signed [VAL_W-1:0] prod;
    logic signed [VAL_W-1:0] val;

    always_comb begin
        norm = {{(VAL_W-ACC_W){acc[ACC_W-1]}}, acc} <<< div_log;
        prod = norm * $signed(k);
        val  = (prod + (VAL_W'(1) <<< (SCALE_SH - 1))) >>> SCALE_SH;
        res  = pack_code(val);
    end
endmodule

// File: rtl/sd_decim_counter.sv
module sd_decim_counter
    import sd_decim_pkg::*;
#(
    parameter int unsigned LEN0 = 10240,
    parameter int unsigned LEN1 = 20480,
    parameter int unsigned LEN2 = 81920,
    parameter int unsigned LEN3 = 102400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [1:0]       div_sel,
    input  logic [1:0]       len_sel,
    input  logic             mod_bit,
    output logic             osc_tick,
    output logic             ready,
    output logic [RES_W-1:0] result
);
    localparam int unsigned LENS [4] = '{LEN0, LEN1, LEN2, LEN3};
    localparam int unsigned MAX_A   = (LEN0 > LEN1) ? LEN0 : LEN1;
    localparam int unsigned MAX_B   = (LEN2 > LEN3) ? LEN2 : LEN3;
    localparam int unsigned MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CYC_W = $clog2(MAX_LEN);
    localparam int ACC_W = $clog2(MAX_LEN + 1) + 1;

    conv_state_e              state_q;
    logic [CYC_W-1:0]         cyc_q;
    logic [1:0]               div_q;
    logic [1:0]               len_q;
    result_t                  hold_q;
    result_t                  fmt_res;
    logic signed [ACC_W-1:0]  acc;
    logic [VAL_W-1:0]         k_tab   [4];
    logic [CYC_W-1:0]         len_tab [4];
    logic                     accept;
    logic [1:0]               div_eff;

    for (genvar g = 0; g < 4; g++) begin : g_len
        localparam logic [VAL_W-1:0] KV = scale_k(LENS[g]);
        assign k_tab[g]   = KV;
        assign len_tab[g] = CYC_W'(LENS[g] - 1);
    end

    assign ready   = (state_q == ST_IDLE);
    assign accept  = start && ready && !abort;
    assign div_eff = ready ? div_sel : div_q;
    assign result  = hold_q;

    sd_osc_div u_div (
        .clk     (clk),
        .rst     (rst),
        .sync    (accept),
        .div_sel (div_eff),
        .tick    (osc_tick)
    );

    sd_updown #(.W(ACC_W)) u_acc (
        .clk (clk),
        .rst (rst),
        .clr (accept || abort),
        .en  ((state_q == ST_RUN) && osc_tick),
        .up  (mod_bit),
        .acc (acc)
    );

    sd_result_fmt #(.ACC_W(ACC_W)) u_fmt (
        .acc     (acc),
        .div_log (div_shift(div_q)),
        .k       (k_tab[len_q]),
        .res     (fmt_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
            div_q   <= '0;
            len_q   <= '0;
            hold_q  <= '0;
        end else if (abort) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RUN;
                    div_q   <= div_sel;
                    len_q   <= len_sel;
                    cyc_q   <= len_tab[len_sel];
                end
                ST_RUN: begin
                    if (cyc_q == '0) state_q <= ST_LOAD;
                    else             cyc_q   <= cyc_q - CYC_W'(1);
                end
                ST_LOAD: begin
                    hold_q  <= fmt_res;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sd_decim_counter_chk.sv
module sd_decim_counter_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        abort,
    input logic        ready,
    input logic        osc_tick,
    input logic [15:0] result,
    input logic [1:0]  div_q
);
    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> ($past(start) && !$past(abort)));

    // R9
    abort_ready_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> ready);

    // R6
    hold_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $rose(ready));

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && div_q[1] && osc_tick) |=> (ready || !osc_tick));
endmodule

bind sd_decim_counter sd_decim_counter_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .abort    (abort),
    .ready    (ready),
    .osc_tick (osc_tick),
    .result   (result),
    .div_q    (div_q)
);

// File: tb/sd_decim_counter_tb.sv
module sd_decim_counter_tb_top;
    localparam int TL0 = 320;
    localparam int TL1 = 640;
    localparam int TL2 = 1280;
    localparam int TL3 = 2560;
    localparam int NV  = 10;
    // {div[15:14], len[13:12], period[11:6], high[5:0]}
    localparam logic [15:0] VEC [NV] = '{
        {2'd0, 2'd0, 6'd10, 6'd7},
        {2'd1, 2'd1, 6'd10, 6'd5},
        {2'd2, 2'd2, 6'd10, 6'd3},
        {2'd0, 2'd1, 6'd10, 6'd10},
        {2'd1, 2'd0, 6'd10, 6'd0},
        {2'd2, 2'd3, 6'd10, 6'd9},
        {2'd3, 2'd0, 6'd10, 6'd1},
        {2'd2, 2'd0, 6'd20, 6'd19},
        {2'd0, 2'd0, 6'd32, 6'd17},
        {2'd1, 2'd1, 6'd32, 6'd15}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic [1:0]  len_sel = 2'd0;
    logic        mod_bit = 1'b0;
    logic        osc_tick;
    logic        ready;
    logic [15:0] result;

    int n_chk = 0;
    int n_fail = 0;
    int src_per = 10;
    int src_hi = 0;
    int idx = 0;
    logic rewind = 1'b0;

    always #2 clk = ~clk;

    sd_decim_counter #(.LEN0(TL0), .LEN1(TL1), .LEN2(TL2), .LEN3(TL3)) dut_i (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .div_sel(div_sel), .len_sel(len_sel), .mod_bit(mod_bit),
        .osc_tick(osc_tick), .ready(ready), .result(result)
    );

    // behavioural modulator: one pattern bit per oversampling tick
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rewind) begin idx = 0; rewind = 1'b0; end
            if (osc_tick) begin
                mod_bit = ((idx % src_per) < src_hi);
                idx++;
            end
        end
    end

    function automatic int len_of(input int l);
        case (l)
            0: return TL0;
            1: return TL1;
            2: return TL2;
            default: return TL3;
        endcase
    endfunction

    function automatic int div_of(input int d);
        return (d == 0) ? 1 : (d == 1) ? 2 : 4;
    endfunction

    function automatic logic [15:0] spec_code(input int d, input int l, input int per, input int hi);
        int dv, ll, n, c, v;
        logic [15:0] r;
        dv = div_of(d);
        ll = len_of(l);
        n  = ll / dv;
        c  = 2 * ((n / per) * hi) - n;
        v  = (c * dv * 20480) / ll;
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        r[15]   = (v < 0);
        r[14]   = (v > 16383) || (v < -16384);
        r[13:0] = 14'(v & 32'h3FFF);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode 0: plain, 1: extra start plus new settings mid-run, 2: new settings only
    task automatic run_conv(input int d, input int l, input int per, input int hi,
                            input int mode, output int width, output logic [15:0] res);
        @(negedge clk);
        div_sel = 2'(d); len_sel = 2'(l);
        src_per = per; src_hi = hi; rewind = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        width = 0;
        for (int i = 0; i < 6000 && !ready; i++) begin
            width++;
            if (mode != 0 && width == 40) begin
                len_sel = 2'(l + 1);
                div_sel = 2'(d + 1);
                if (mode == 1) start = 1'b1;
            end
            if (width == 41) start = 1'b0;
            @(negedge clk);
        end
        res = result;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w;
        int ticks;
        logic [15:0] r;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", 32'(ready), 32'd1);
        check("R1 result after reset", 32'(result), 32'h0);

        // R3: tick rate in idle for each divide setting
        for (int d = 0; d < 4; d++) begin
            div_sel = 2'(d);
            repeat (8) @(negedge clk);
            ticks = 0;
            for (int i = 0; i < 40; i++) begin
                if (osc_tick) ticks++;
                @(negedge clk);
            end
            check("R3 tick count", 32'(ticks), 32'(40 / div_of(d)));
        end

        // R2 R4 R5 R6: vector table
        for (int v = 0; v < NV; v++) begin
            int d, l, per, hi;
            d = int'(VEC[v][15:14]); l = int'(VEC[v][13:12]);
            per = int'(VEC[v][11:6]); hi = int'(VEC[v][5:0]);
            run_conv(d, l, per, hi, 0, w, r);
            check("R2 busy width", 32'(w), 32'(len_of(l) + 1));
            check("R4/R5/R6 result", 32'(r), 32'(spec_code(d, l, per, hi)));
        end

        // R7: start during a conversion (with other settings on the pins)
        run_conv(1, 0, 10, 7, 1, w, r);
        check("R7 width with extra start", 32'(w), 32'(TL0 + 1));
        check("R7 result with extra start", 32'(r), 32'(spec_code(1, 0, 10, 7)));

        // R8: settings changed mid-run
        run_conv(2, 1, 10, 3, 2, w, r);
        check("R8 width with new settings", 32'(w), 32'(TL1 + 1));
        check("R8 result with new settings", 32'(r), 32'(spec_code(2, 1, 10, 3)));

        // R9: abort keeps the held word
        held = result;
        @(negedge clk);
        div_sel = 2'd0; len_sel = 2'd3; src_per = 10; src_hi = 10; rewind = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        check("R9 busy before abort", 32'(ready), 32'd0);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R9 ready after abort", 32'(ready), 32'd1);
        check("R9 result kept", 32'(result), 32'(held));
        repeat (20) @(negedge clk);
        check("R9 result still kept", 32'(result), 32'(held));
        run_conv(0, 0, 10, 9, 0, w, r);
        check("R9 clean run after abort", 32'(r), 32'(spec_code(0, 0, 10, 9)));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule